// File: doc/BRIEF.md
# PLL Lock Flag Detector

This block sits beside the phase/frequency detector of a frequency synthesizer and keeps a single lock flag up to date. It runs on the reference crystal clock. It treats every crystal cycle in which the UP or the DOWN pump request is high as one unit of pump-pulse width, and it adds these units up over one comparison period. A strobe marks the last crystal cycle of each comparison period.

The flag behaves with deliberately uneven hysteresis. A single pump pulse that grows wider than the allowed width drops the flag straight away, in the middle of the period. The flag comes back only after a full run of consecutive comparison periods whose pulses all stayed within the limit. A period in which the pump never fires counts as a clean period.

With the defaults, the allowed width is one crystal cycle and the clean run is eight periods. At a 62.5 kHz comparison rate, this gives a loss indication within one period and a regain delay of 128 to 144 µs.

Top module: `pll_lock_detect`

## Requirements
- R1: After reset, lockFlag is 0 and the clean-period run count is 0, so a full run of GOOD_RUN clean periods is needed before the flag can rise.
- R2: The pulse width of a period is the number of crystal cycles in that period in which pumpUp or pumpDown is high. A cycle with both high counts once. Separate pulses in the same period add up.
- R3: A period is wide once its width exceeds MAX_WIDTH cycles (default 1). On the edge that ends the (MAX_WIDTH+1)-th active cycle, lockFlag goes to 0, without waiting for the strobe.
- R4: lockFlag goes to 1 on the edge that ends the strobe cycle of the GOOD_RUN-th consecutive clean period (default 8), and not earlier.
- R5: A comparison period with no active pump cycle counts as a clean period.
- R6: A wide period sets the clean-period run count back to 0, so a full new run of GOOD_RUN clean periods is needed to set the flag again.
- R7: Once lockFlag is 1, further clean periods keep it at 1. The run count saturates at GOOD_RUN.
- R8: A period whose width is exactly MAX_WIDTH cycles is clean.
- R9: An active pump cycle that coincides with periodStrobe counts toward the period that is ending. The width count of the next period starts from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| pumpUp | input | 1 | Charge-pump up request from the phase detector |
| pumpDown | input | 1 | Charge-pump down request from the phase detector |
| periodStrobe | input | 1 | High in the last crystal cycle of each comparison period |
| lockFlag | output | 1 | Lock indication, 1 when locked |

## Verification
Directed periods cover the following cases:
- a width exactly at the limit against one cycle more, which separates a good period from a wide one at the boundary;
- both pump lines high in the same cycle against the two lines firing in different cycles, which shows whether width counts cycles or pulses;
- pump activity in the strobe cycle, which shows which period that cycle is charged to;
- runs of seven and of eight clean periods, with a wide period breaking a run, which pins the exact edge of the rise and the restart of the count.

Seeded random periods of random length, with random UP and DOWN activity, are then compared cycle by cycle against a model of the requirements held in the bench.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;
  // Strobes from the judge to the width meter
  typedef struct packed {
    logic countEn;      // a pump line is active this cycle
    logic clearPeriod;  // this cycle closes the comparison period
  } meterCtl_t;
endpackage

// File: rtl/lockdet_meter.sv
module lockdet_meter
  import lockdet_pkg::*;
#(
  parameter int MAX_WIDTH = 1
) (
  input  logic clk,
  input  logic rstN,
  input  meterCtl_t ctl,
  output logic tooWide,
  output logic periodBad,
  output logic [$clog2(MAX_WIDTH+2)-1:0] widthCnt
);
  localparam int CW = $clog2(MAX_WIDTH + 2);
  localparam logic [CW-1:0] SAT = CW'(MAX_WIDTH + 1);
  localparam logic [CW-1:0] LIMIT = CW'(MAX_WIDTH);

  logic badSeen;

  // The cycle that pushes the width past the limit
  assign tooWide   = ctl.countEn && (widthCnt >= LIMIT);
  assign periodBad = badSeen || tooWide;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      widthCnt <= '0;
      badSeen  <= 1'b0;
    end else if (ctl.clearPeriod) begin
      widthCnt <= '0;
      badSeen  <= 1'b0;
    end else begin
      if (ctl.countEn && widthCnt != SAT) widthCnt <= widthCnt + 1'b1;
      if (tooWide) badSeen <= 1'b1;
    end
  end
endmodule

// File: rtl/lockdet_judge.sv
module lockdet_judge
  import lockdet_pkg::*;
#(
  parameter int GOOD_RUN = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic pumpUp,
  input  logic pumpDown,
  input  logic periodStrobe,
  input  logic tooWide,
  input  logic periodBad,
  output meterCtl_t ctl,
  output logic [$clog2(GOOD_RUN+1)-1:0] goodCnt,
  output logic lockFlag
);
  localparam int GW = $clog2(GOOD_RUN + 1);
  localparam logic [GW-1:0] RUN = GW'(GOOD_RUN);

  logic [GW-1:0] goodNext;

  always_comb begin
    ctl.countEn     = pumpUp | pumpDown;
    ctl.clearPeriod = periodStrobe;
    goodNext = (goodCnt == RUN) ? RUN : goodCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      goodCnt  <= '0;
      lockFlag <= 1'b0;
    end else if (tooWide) begin
      // a wide pulse drops lock at once and restarts the run
      goodCnt  <= '0;
      lockFlag <= 1'b0;
    end else if (periodStrobe) begin
      if (periodBad) begin
        goodCnt <= '0;
      end else begin
        goodCnt <= goodNext;
        if (goodNext == RUN) lockFlag <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pll_lock_detect.sv
module pll_lock_detect
  import lockdet_pkg::*;
#(
  parameter int MAX_WIDTH = 1,
  parameter int GOOD_RUN  = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic pumpUp,
  input  logic pumpDown,
  input  logic periodStrobe,
  output logic lockFlag
);
  localparam int CW = $clog2(MAX_WIDTH + 2);
  localparam int GW = $clog2(GOOD_RUN + 1);

  meterCtl_t ctl;
  logic tooWide;
  logic periodBad;
  logic [CW-1:0] widthCnt;
  logic [GW-1:0] goodCnt;

  lockdet_meter #(.MAX_WIDTH(MAX_WIDTH)) meter (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .tooWide(tooWide), .periodBad(periodBad), .widthCnt(widthCnt)
  );

  lockdet_judge #(.GOOD_RUN(GOOD_RUN)) judge (
    .clk(clk), .rstN(rstN), .pumpUp(pumpUp), .pumpDown(pumpDown),
    .periodStrobe(periodStrobe), .tooWide(tooWide), .periodBad(periodBad),
    .ctl(ctl), .goodCnt(goodCnt), .lockFlag(lockFlag)
  );
endmodule

// File: rtl/pll_lock_detect_chk.sv
module pll_lock_detect_chk #(
  parameter int MAX_WIDTH = 1,
  parameter int GOOD_RUN  = 8
) (
  input logic clk,
  input logic rstN,
  input logic periodStrobe,
  input logic lockFlag,
  input logic tooWide,
  input logic [$clog2(GOOD_RUN+1)-1:0] goodCnt,
  input logic [$clog2(MAX_WIDTH+2)-1:0] widthCnt
);
  localparam int GW = $clog2(GOOD_RUN + 1);

  // R3: a wide pulse leaves the flag low on the next cycle
  a_r3_wide_clears: assert property (@(posedge clk) disable iff (!rstN)
    tooWide |=> !lockFlag);

  // R4: the flag rises only at a period boundary
  a_r4_rise_on_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockFlag) |-> $past(periodStrobe));

  // R4: the flag rises with a complete run behind it
  a_r4_rise_full_run: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockFlag) |-> goodCnt == GW'(GOOD_RUN));

  // R6: a set flag always has a full run behind it
  a_r6_flag_needs_run: assert property (@(posedge clk) disable iff (!rstN)
    lockFlag |-> goodCnt == GW'(GOOD_RUN));

  // R7: the run count never passes its saturation value
  a_r7_good_bounded: assert property (@(posedge clk) disable iff (!rstN)
    goodCnt <= GW'(GOOD_RUN));

  // R9: each period starts its width count from zero
  a_r9_width_restarts: assert property (@(posedge clk) disable iff (!rstN)
    periodStrobe |=> widthCnt == '0);
endmodule

bind pll_lock_detect pll_lock_detect_chk #(.MAX_WIDTH(MAX_WIDTH), .GOOD_RUN(GOOD_RUN)) chk (
  .clk(clk), .rstN(rstN), .periodStrobe(periodStrobe), .lockFlag(lockFlag),
  .tooWide(tooWide), .goodCnt(goodCnt), .widthCnt(widthCnt)
);

// File: tb/pll_lock_detect_test.sv
`timescale 1ns/1ps
module pll_lock_detect_test;
  localparam int MAXW = 1;
  localparam int RUN  = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pumpUp = 1'b0, pumpDown = 1'b0, periodStrobe = 1'b0;
  logic lockFlag;

  int checks = 0, fails = 0;
  int refWidth = 0, refGood = 0;
  logic refBad = 1'b0, refFlag = 1'b0;

  always #10 clk = ~clk;

  pll_lock_detect #(.MAX_WIDTH(MAXW), .GOOD_RUN(RUN)) uut (
    .clk(clk), .rstN(rstN), .pumpUp(pumpUp), .pumpDown(pumpDown),
    .periodStrobe(periodStrobe), .lockFlag(lockFlag)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s lockFlag=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // expected next state of the flag model, from the requirements
  function automatic logic nextFlag(input logic u, input logic d, input logic s);
    logic act, wide;
    act  = u | d;
    wide = act && (refWidth >= MAXW);
    if (wide) begin
      refGood = 0;
      refFlag = 1'b0;
    end else if (s) begin
      if (refBad) refGood = 0;
      else begin
        if (refGood < RUN) refGood++;
        if (refGood == RUN) refFlag = 1'b1;
      end
    end
    if (s) begin
      refWidth = 0;
      refBad = 1'b0;
    end else begin
      if (act && refWidth <= MAXW) refWidth++;
      if (wide) refBad = 1'b1;
    end
    return refFlag;
  endfunction

  // one crystal cycle: drive after the falling edge, sample mid-high phase
  task automatic tick(input logic u, input logic d, input logic s, input string tag);
    logic exp;
    pumpUp = u; pumpDown = d; periodStrobe = s;
    exp = nextFlag(u, d, s);
    @(posedge clk); #5;
    check(tag, lockFlag, exp);
    @(negedge clk);
  endtask

  // a comparison period of len cycles; bit i of the masks drives cycle i
  task automatic period(input int len, input logic [31:0] upM, input logic [31:0] dnM,
                        input string tag);
    for (int i = 0; i < len; i++)
      tick(upM[i], dnM[i], (i == len - 1), tag);
  endtask

  initial begin
    #(200000 * 20);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1 reset", lockFlag, 1'b0);
    rstN = 1'b1;

    // R1/R5/R8: seven clean periods (idle, single-cycle pulses) do not set the flag
    period(16, 32'h0, 32'h0, "R5 idle period");
    period(16, 32'h4, 32'h0, "R8 width at limit");
    period(16, 32'h0, 32'h8, "R8 down pulse at limit");
    period(16, 32'h10, 32'h10, "R2 both lines one cycle");
    period(16, 32'h0, 32'h0, "R5 idle period");
    period(16, 32'h0, 32'h0, "R5 idle period");
    period(16, 32'h0, 32'h0, "R1 seventh clean period");
    check("R4 flag low after seven", lockFlag, 1'b0);
    period(16, 32'h0, 32'h0, "R4 eighth clean period");
    check("R4 flag high after eight", lockFlag, 1'b1);
    period(16, 32'h2, 32'h0, "R7 stays set");
    check("R7 flag held", lockFlag, 1'b1);

    // R3: two active cycles drop the flag mid period
    period(16, 32'h30, 32'h0, "R3 wide pulse clears");
    check("R3 flag low", lockFlag, 1'b0);

    // R6: a wide period in the middle of a run restarts it
    repeat (5) period(12, 32'h0, 32'h0, "R6 partial run");
    period(12, 32'h1, 32'h4, "R2 split pulses are wide");
    repeat (7) period(12, 32'h0, 32'h0, "R6 restarted run");
    check("R6 still low after seven", lockFlag, 1'b0);
    period(12, 32'h0, 32'h0, "R6 run complete");
    check("R6 set after eight", lockFlag, 1'b1);

    // R9: activity in the strobe cycle belongs to the ending period
    period(10, 32'h201, 32'h0, "R9 strobe cycle counted");
    check("R9 flag low", lockFlag, 1'b0);
    period(10, 32'h200, 32'h0, "R9 strobe-only pulse");
    period(10, 32'h1, 32'h0, "R9 next period from zero");
    repeat (6) period(10, 32'h0, 32'h0, "R9 run");
    check("R9 set after eight", lockFlag, 1'b1);

    // random periods against the model
    for (int n = 0; n < 600; n++) begin
      int len;
      logic [31:0] um, dm;
      len = 4 + int'($urandom % 20);
      um = 32'h0; dm = 32'h0;
      case ($urandom % 4)
        0: ;
        1: um[$urandom % len] = 1'b1;
        2: dm[$urandom % len] = 1'b1;
        default: begin um = $urandom & $urandom & $urandom; dm = $urandom & $urandom & $urandom; end
      endcase
      period(len, um, dm, "R2 random");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule